// File: doc/BRIEF.md
# Digit-Run Compressing Character Queue

This block is a byte queue placed between a producer of ASCII text and a consumer. Text characters go in one per cycle and come out in the same order. Runs of decimal digits are not stored as characters. Each run is turned, as it arrives, into a compact number record. A record is one marker byte followed by a fixed count of binary value bytes.

The producer offers a character with `ins_req` and may only do so while `can_insert` is high. The consumer reads the byte shown on `char_out` whenever `can_remove` is high, and pulses `rem_req` to advance. The consumer rebuilds the original text as follows:
- Every byte other than the marker is copied as a character.
- A marker is followed by `NUM_BYTES` bytes. These are assembled into an unsigned value and printed as a decimal number with no leading zeros.

A digit run is cut into chunks wherever that is needed to keep this rebuild exact. The input text is assumed never to contain the marker code itself.

The parameters are:
- `DEPTH_LG`: log2 of the storage depth.
- `NUM_BYTES`: the count of value bytes per record.
- `IDLE_GAP`: how many input-idle cycles a partly collected number may wait before it is written out.

Top module: `cdq_digit_queue`

## Requirements
- R1: A byte with code 48 to 57 inclusive is a digit. Every other accepted byte is written to the queue unchanged and in arrival order.
- R2: A number record is written as the marker byte 1, followed by exactly NUM_BYTES bytes of the value, most significant byte first.
- R3: A chunk never starts with a zero. A '0' (code 48) accepted while no number is pending is written as a plain character. When appending a digit would push the pending value above 2^(8*NUM_BYTES)-1, the pending value is written as a record and the digit starts a new chunk, under the same zero rule.
- R4: When a non-digit is accepted while a number is pending, the number's record is written first, and the non-digit is written directly after it.
- R5: When IDLE_GAP consecutive cycles pass with no accepted insert while a number is pending, its record is written without any further input.
- R6: can_remove is high exactly when the queue holds a byte. char_out shows the oldest byte. An accepted removal advances to the next byte. Without a removal, the head byte holds steady.
- R7: can_insert is low while a record is being written, and whenever fewer than NUM_BYTES+2 free slots remain. An insert request while can_insert is low is ignored. Storage never overflows.
- R8: A remove request while can_remove is low is ignored and does not disturb the order of later bytes.
- R9: Synchronous active-high reset empties the queue. In the cycle after reset, can_insert reads 1 and can_remove reads 0.
- R10: Rebuilding the output stream reproduces the input text exactly, under any pattern of insert and remove timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_in | input | 8 | Character offered by the producer |
| ins_req | input | 1 | Producer insert request |
| can_insert | output | 1 | Queue can take a character this cycle |
| rem_req | input | 1 | Consumer removal request |
| can_remove | output | 1 | A byte is available at the head |
| char_out | output | 8 | Byte at the head of the queue |

## Verification
The assertions check the following on every cycle:
- Storage is never written while full.
- Inserts stay blocked for the whole time a record is being written.
- Every record begins with the marker byte.
- The head byte stays put when nothing is removed.
- An empty queue stays empty unless something is written.
- The post-reset flag values are correct.

The bench scenarios are needed for the value-level behaviour: the chunk boundaries, the leading-zero rule, the split on overflow, the idle flush and the byte-exact round trip. This requires comparing the whole output stream with an encoder model and a decoder.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    localparam logic [7:0] MARK_CODE  = 8'd1;
    localparam logic [7:0] ZERO_CODE  = 8'd48;
    localparam logic [7:0] NINE_CODE  = 8'd57;

    typedef enum logic [1:0] {
        EMIT_IDLE,
        EMIT_MARK,
        EMIT_VALUE,
        EMIT_TRAIL
    } emit_state_t;

    typedef struct packed {
        logic       trail;
        logic [7:0] trail_char;
    } trail_t;

    function automatic logic is_digit(input logic [7:0] c);
        return (c >= ZERO_CODE) && (c <= NINE_CODE);
    endfunction

endpackage

// File: rtl/cdq_ring.sv
module cdq_ring #(
    parameter int DEPTH_LG = 4,
    parameter int RESERVE  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       re,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       full,
    output logic       roomy
);
    localparam int DEPTH = 1 << DEPTH_LG;
    localparam int CW    = DEPTH_LG + 1;
    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - 1 - RESERVE);

    logic [7:0]          mem [DEPTH];
    logic [DEPTH_LG-1:0] wr_ptr, rd_ptr;
    logic [DEPTH_LG-1:0] used;

    assign used  = wr_ptr - rd_ptr;
    assign empty = (wr_ptr == rd_ptr);
    assign full  = (DEPTH_LG'(wr_ptr + 1'b1) == rd_ptr);
    assign roomy = ({1'b0, used} <= ROOM_LIMIT);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (we && !full) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (we && !full) wr_ptr <= wr_ptr + 1'b1;
            if (re && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/cdq_emitter.sv
module cdq_emitter
    import cdq_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [8*NUM_BYTES-1:0] start_val,
    input  trail_t                 start_trail,
    output logic                   busy,
    output logic                   wr_en,
    output logic [7:0]             wr_byte
);
    localparam int VW = 8 * NUM_BYTES;
    localparam int IW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_BYTES - 1);

    emit_state_t     st;
    logic [VW-1:0]   snap;
    trail_t          trl;
    logic [IW-1:0]   idx;
    logic [VW-1:0]   shifted;

    assign busy  = (st != EMIT_IDLE);
    assign wr_en = busy;

    always_comb begin
        shifted = snap >> (8 * (int'(LAST_IDX) - int'(idx)));
        case (st)
            EMIT_MARK:  wr_byte = MARK_CODE;
            EMIT_VALUE: wr_byte = shifted[7:0];
            EMIT_TRAIL: wr_byte = trl.trail_char;
            default:    wr_byte = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= EMIT_IDLE;
            snap <= '0;
            trl  <= '0;
            idx  <= '0;
        end else begin
            case (st)
                EMIT_IDLE: if (start) begin
                    snap <= start_val;
                    trl  <= start_trail;
                    st   <= EMIT_MARK;
                end
                EMIT_MARK: begin
                    idx <= '0;
                    st  <= EMIT_VALUE;
                end
                EMIT_VALUE: begin
                    if (idx == LAST_IDX) st <= trl.trail ? EMIT_TRAIL : EMIT_IDLE;
                    else                 idx <= idx + 1'b1;
                end
                default: st <= EMIT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cdq_digit_queue.sv
module cdq_digit_queue
    import cdq_pkg::*;
#(
    parameter int DEPTH_LG  = 4,
    parameter int NUM_BYTES = 2,
    parameter int IDLE_GAP  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] char_in,
    input  logic       ins_req,
    output logic       can_insert,
    input  logic       rem_req,
    output logic       can_remove,
    output logic [7:0] char_out
);
    localparam int VW = 8 * NUM_BYTES;
    localparam int GW = $clog2(IDLE_GAP + 1);
    localparam logic [GW-1:0] GAP_END = GW'(IDLE_GAP);

    logic            pend, pend_n;
    logic [VW-1:0]   val, val_n;
    logic [GW-1:0]   idle_cnt;
    logic            acc, dig, fits, timeout;
    logic [3:0]      dval;
    logic [VW+3:0]   wide, grown;

    logic            fl_start, fl_busy, fl_we;
    logic [VW-1:0]   fl_val;
    trail_t          fl_trail;
    logic [7:0]      fl_byte;

    logic            dir_we;
    logic            ring_we;
    logic [7:0]      ring_wdata;
    logic            ring_empty, ring_full, ring_roomy;

    assign acc     = ins_req && can_insert;
    assign dig     = is_digit(char_in);
    assign dval    = 4'(char_in - ZERO_CODE);
    assign wide    = {4'b0, val};
    assign grown   = (wide << 3) + (wide << 1) + (VW+4)'(dval);
    assign fits    = (grown[VW+3:VW] == 4'd0);
    assign timeout = (idle_cnt == GAP_END);

    always_comb begin
        fl_start = 1'b0;
        fl_val   = val;
        fl_trail = '{trail: 1'b0, trail_char: char_in};
        dir_we   = 1'b0;
        pend_n   = pend;
        val_n    = val;
        if (acc) begin
            if (dig) begin
                if (pend && fits) begin
                    val_n = grown[VW-1:0];
                end else begin
                    if (pend) begin
                        fl_start = 1'b1;
                        pend_n   = 1'b0;
                    end
                    if (dval == 4'd0) begin
                        if (pend) fl_trail.trail = 1'b1;
                        else      dir_we = 1'b1;
                    end else begin
                        pend_n = 1'b1;
                        val_n  = VW'(dval);
                    end
                end
            end else if (pend) begin
                fl_start       = 1'b1;
                fl_trail.trail = 1'b1;
                pend_n         = 1'b0;
            end else begin
                dir_we = 1'b1;
            end
        end else if (pend && timeout && !fl_busy && ring_roomy) begin
            fl_start = 1'b1;
            pend_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            val  <= '0;
        end else begin
            pend <= pend_n;
            val  <= val_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || acc || !pend) begin
            idle_cnt <= '0;
        end else if (!fl_busy && !timeout) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    cdq_emitter #(.NUM_BYTES(NUM_BYTES)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .start      (fl_start),
        .start_val  (fl_val),
        .start_trail(fl_trail),
        .busy       (fl_busy),
        .wr_en      (fl_we),
        .wr_byte    (fl_byte)
    );

    assign ring_we    = dir_we || fl_we;
    assign ring_wdata = fl_we ? fl_byte : char_in;

    cdq_ring #(.DEPTH_LG(DEPTH_LG), .RESERVE(NUM_BYTES + 2)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .we   (ring_we),
        .wdata(ring_wdata),
        .re   (rem_req),
        .rdata(char_out),
        .empty(ring_empty),
        .full (ring_full),
        .roomy(ring_roomy)
    );

    assign can_insert = !fl_busy && ring_roomy;
    assign can_remove = !ring_empty;

endmodule

// File: rtl/cdq_checker.sv
module cdq_checker (
    input logic       clk,
    input logic       rst,
    input logic       can_insert,
    input logic       can_remove,
    input logic       rem_req,
    input logic [7:0] char_out,
    input logic       ring_we,
    input logic       ring_full,
    input logic [7:0] ring_wdata,
    input logic       fl_busy
);
    // R7: storage never written while full
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ring_we |-> !ring_full);

    // R7: no inserts while a record is being written
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        fl_busy |-> !can_insert);

    // R2: every record opens with the marker byte
    p_marker_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_busy) |-> (ring_we && ring_wdata == 8'd1));

    // R6: head byte holds while nothing is removed
    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (can_remove && !rem_req) |=> (can_remove && $stable(char_out)));

    // R8: an empty queue stays empty without a write
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!can_remove && !ring_we) |=> !can_remove);

    // R9: flags right after reset
    p_reset_flags_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (can_insert && !can_remove));

endmodule

bind cdq_digit_queue cdq_checker u_cdq_checker (
    .clk       (clk),
    .rst       (rst),
    .can_insert(can_insert),
    .can_remove(can_remove),
    .rem_req   (rem_req),
    .char_out  (char_out),
    .ring_we   (ring_we),
    .ring_full (ring_full),
    .ring_wdata(ring_wdata),
    .fl_busy   (fl_busy)
);

// File: tb/test_cdq_digit_queue.sv
`timescale 1ns/1ps
module test_cdq_digit_queue;
    localparam int DEPTH_LG  = 4;
    localparam int NUM_BYTES = 2;
    localparam int IDLE_GAP  = 8;
    localparam int DEPTH     = 1 << DEPTH_LG;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] char_in = 8'd0;
    logic       ins_req = 1'b0;
    logic       rem_req = 1'b0;
    logic       can_insert, can_remove;
    logic [7:0] char_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit feed_done;
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    cdq_digit_queue #(.DEPTH_LG(DEPTH_LG), .NUM_BYTES(NUM_BYTES), .IDLE_GAP(IDLE_GAP)) i_cdq_digit_queue (
        .clk(clk), .rst(rst), .char_in(char_in), .ins_req(ins_req),
        .can_insert(can_insert), .rem_req(rem_req),
        .can_remove(can_remove), .char_out(char_out)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    function automatic string show(input logic [7:0] q[$]);
        string s = "";
        foreach (q[i]) s = $sformatf("%s %02h", s, q[i]);
        return s;
    endfunction

    function automatic void emit_rec(ref logic [7:0] q[$], input longint v);
        for (int k = NUM_BYTES - 1; k >= 0; k--) begin
            if (k == NUM_BYTES - 1) q.push_back(8'd1);
            q.push_back(8'((v >> (8 * k)) & 255));
        end
    endfunction

    function automatic void model(input string s, ref logic [7:0] q[$]);
        longint maxv = (longint'(1) << (8 * NUM_BYTES)) - 1;
        longint v = 0;
        bit pend = 0;
        q = {};
        for (int i = 0; i < s.len(); i++) begin
            byte c = s[i];
            if (c >= 48 && c <= 57) begin
                longint d = longint'(c) - 48;
                if (pend && v * 10 + d <= maxv) v = v * 10 + d;
                else begin
                    if (pend) begin emit_rec(q, v); pend = 0; end
                    if (d == 0) q.push_back(8'd48);
                    else begin pend = 1; v = d; end
                end
            end else begin
                if (pend) begin emit_rec(q, v); pend = 0; end
                q.push_back(8'(c));
            end
        end
        if (pend) emit_rec(q, v);
    endfunction

    function automatic string decode(input logic [7:0] q[$]);
        string out = "";
        int i = 0;
        while (i < q.size()) begin
            if (q[i] == 8'd1) begin
                longint v = 0;
                for (int k = 1; k <= NUM_BYTES; k++)
                    if (i + k < q.size()) v = (v << 8) | longint'(q[i + k]);
                out = $sformatf("%s%0d", out, v);
                i += NUM_BYTES + 1;
            end else begin
                out = $sformatf("%s%c", out, q[i]);
                i++;
            end
        end
        return out;
    endfunction

    task automatic feed(input string s, input bit rnd);
        int i = 0;
        while (i < s.len()) begin
            @(negedge clk);
            if (can_insert && (!rnd || ($urandom % 2 == 0))) begin
                char_in = s[i];
                ins_req = 1'b1;
                i++;
            end else begin
                ins_req = 1'b0;
            end
        end
        @(negedge clk);
        ins_req = 1'b0;
        feed_done = 1;
    endtask

    task automatic drain(input bit rnd);
        int quiet = 0;
        while (!feed_done || quiet < 4 * IDLE_GAP) begin
            @(negedge clk);
            if (can_remove && (!rnd || ($urandom % 3 != 0))) begin
                got.push_back(char_out);
                rem_req = 1'b1;
                quiet = 0;
            end else begin
                rem_req = 1'b0;
                if (!can_remove) quiet++;
            end
        end
        rem_req = 1'b0;
    endtask

    task automatic run(input string s, input bit rnd);
        got = {};
        feed_done = 0;
        fork
            feed(s, rnd);
            drain(rnd);
        join
    endtask

    task automatic exact(input string s, input string req);
        logic [7:0] exp[$];
        model(s, exp);
        run(s, 0);
        check(got == exp, req, show(got), show(exp));
        check(decode(got) == s, {req, " round trip"}, decode(got), s);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(can_insert === 1'b1, "R9 can_insert", $sformatf("%b", can_insert), "1");
        check(can_remove === 1'b0, "R9 can_remove", $sformatf("%b", can_remove), "0");
    endtask

    task automatic t_idle_flush();
        logic [7:0] exp[$];
        got = {};
        @(negedge clk); char_in = "4"; ins_req = 1'b1;
        @(negedge clk); char_in = "2";
        @(negedge clk); ins_req = 1'b0;
        repeat (3 * IDLE_GAP) @(negedge clk);
        check(can_remove === 1'b1, "R5 record present", $sformatf("%b", can_remove), "1");
        while (can_remove) begin
            got.push_back(char_out);
            rem_req = 1'b1;
            @(negedge clk);
            rem_req = 1'b0;
            @(negedge clk);
        end
        emit_rec(exp, 42);
        check(got == exp, "R5 idle flush", show(got), show(exp));
    endtask

    task automatic t_backpressure();
        int accepted = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            @(negedge clk);
            if (can_insert) begin
                char_in = 8'(65 + accepted);
                ins_req = 1'b1;
                accepted++;
            end else begin
                char_in = "Z";
                ins_req = 1'b1;
            end
        end
        @(negedge clk);
        ins_req = 1'b0;
        check(accepted == DEPTH - 1 - (NUM_BYTES + 2) + 1, "R7 accepted count",
              $sformatf("%0d", accepted), $sformatf("%0d", DEPTH - NUM_BYTES - 2));
        got = {};
        while (can_remove) begin
            got.push_back(char_out);
            rem_req = 1'b1;
            @(negedge clk);
            rem_req = 1'b0;
            @(negedge clk);
        end
        begin
            bit ok = (got.size() == accepted);
            foreach (got[i]) if (got[i] != 8'(65 + i)) ok = 0;
            check(ok, "R7 ignored inserts", show(got), "ascending letters, no Z");
        end
    endtask

    task automatic t_empty_remove();
        @(negedge clk); rem_req = 1'b1;
        repeat (3) @(negedge clk);
        rem_req = 1'b0;
        check(can_remove === 1'b0, "R8 still empty", $sformatf("%b", can_remove), "0");
        char_in = "A"; ins_req = 1'b1;
        @(negedge clk); ins_req = 1'b0;
        char_in = "B"; ins_req = 1'b1;
        @(negedge clk); ins_req = 1'b0;
        check(can_remove === 1'b1 && char_out === "A", "R8 head after empty remove",
              $sformatf("%b/%02h", can_remove, char_out), "1/41");
        repeat (2) @(negedge clk);
        check(char_out === "A", "R6 head steady", $sformatf("%02h", char_out), "41");
        rem_req = 1'b1;
        @(negedge clk);
        check(char_out === "B", "R6 advance", $sformatf("%02h", char_out), "42");
        @(negedge clk);
        rem_req = 1'b0;
        check(can_remove === 1'b0, "R6 empty after drain", $sformatf("%b", can_remove), "0");
    endtask

    task automatic t_random();
        string s = "One 1 two 12 three 317 x 0 y 007 big 65535 over 70000 long 1234567890. 60 s 31536000!";
        for (int r = 0; r < 3; r++) begin
            run(s, 1);
            check(decode(got) == s, "R10 random timing", decode(got), s);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        exact("Hi, there!", "R1 plain text");
        exact("x 317 y", "R2 R4 record then char");
        exact("a007b", "R3 leading zeros");
        exact("n70000;", "R3 overflow split");
        exact("0", "R3 lone zero");
        t_idle_flush();
        t_empty_remove();
        t_backpressure();
        t_random();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule